// File: doc/BRIEF.md
# Shared-Bus I2C Clock Phase Synchronizer

This block produces the SCL clock of an I2C master on a bus that other masters share and that slaves may stretch. The block can only pull the line low through an output-enable, and it never drives it high. It reads the resolved wired-AND level back through a two-flop synchronizer. Each low and high phase is timed by one counter against the level the block observes, not against its own drive. A falling edge from any device starts the low phase. A line that stays low after the block has released it puts the block in a wait state. As a result, the bus clock follows the longest low phase and the shortest high phase among the masters.

Software-facing logic is outside this block. The low and high phase lengths arrive as plain count inputs and are captured when the block leaves its idle state. The status pins tell a data shifter where the clock is: the synchronized level, single-cycle edge strobes, and a wait flag. No data stream crosses this block, so every pin is a plain control or status signal and none has valid/ready flow control. Data shifting, START/STOP generation and SDA arbitration belong to other blocks.

Top module: `scl_clock_sync`

## Requirements
- R1: After reset, with `en` low, `scl_oe` is 0, `clk_active` is 0, `hold_wait` is 0 and `scl_level` reads 1.
- R2: The low count starts on the cycle after an observed SCL falling edge and restarts on every such edge. With the block alone on the bus, `scl_oe` therefore stays 1 for max(L,1)+3 consecutive cycles, where L is the captured low count and 3 is the observation latency.
- R3: With the block alone on the bus, `scl_oe` stays 0 for max(H,1)+3 consecutive cycles between pulls, where H is the captured high count.
- R4: A count input of 0 behaves exactly like a count of 1.
- R5: When its low count expires, the block releases SCL (`scl_oe`=0). If the line still reads low, `hold_wait` is 1 and the block neither counts nor pulls.
- R6: The wait has no timeout. After the line is released, `hold_wait` clears and `scl_oe` reasserts exactly max(H,1)+3 cycles later.
- R7: If the line falls during the block's high count, the high count is abandoned. `scl_oe` rises on the third cycle after the line falls and is held for max(L,1) cycles.
- R8: `fall_stb` and `rise_stb` are one-cycle pulses, one for each synchronized falling or rising edge of SCL.
- R9: `low_cnt` and `high_cnt` are captured only when the block leaves idle. Changing them while enabled does not alter the phase lengths.
- R10: Deasserting `en` releases SCL and clears `clk_active` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enables clock generation |
| low_cnt | input | CNT_W | Low phase length in system cycles (0 acts as 1) |
| high_cnt | input | CNT_W | High phase length in system cycles (0 acts as 1) |
| scl_i | input | 1 | Resolved SCL bus level |
| scl_oe | output | 1 | 1 pulls SCL low; 0 releases it |
| scl_level | output | 1 | Synchronized SCL level |
| hold_wait | output | 1 | Block has released SCL but the line is held low by another device |
| clk_active | output | 1 | Block is out of idle |
| fall_stb | output | 1 | One-cycle pulse on a synchronized SCL falling edge |
| rise_stb | output | 1 | One-cycle pulse on a synchronized SCL rising edge |

## Verification
A wrong phase state or a stray counter value shows at `scl_oe` within one clock period, as a pull or release that is cycles too long or too short. The bench measures these lengths directly at the pin. A wait state that is lost or entered wrongly shows as a pull that begins while another device still holds the line, or as a release-to-pull delay that differs from H+3 after a stretch. A synchronizer or edge detector with the wrong depth shifts every measured phase by the same number of cycles, so each table row catches it.

// File: rtl/scl_sync_pkg.sv
package scl_sync_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_HWAIT = 3'd1,
    PH_HIGH  = 3'd2,
    PH_PULL  = 3'd3,
    PH_LOW   = 3'd4
  } phase_e;
endpackage

// File: rtl/scl_in_sync.sv
module scl_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  output logic level,
  output logic fall_stb,
  output logic rise_stb
);
  logic [STAGES-1:0] chain;
  logic              last;

  // the line idles high, so the flops reset to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      last  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], scl_raw};
      last  <= chain[STAGES-1];
    end
  end

  assign level    = chain[STAGES-1];
  assign fall_stb = last & ~level;
  assign rise_stb = ~last & level;

  // R8: an edge strobe never lasts two cycles
  a_r8_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |=> !fall_stb);
  a_r8_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> !rise_stb);
endmodule

// File: rtl/scl_period_cnt.sv
module scl_period_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  input  logic [W-1:0] lim,
  output logic         expired
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (run) cnt <= cnt + ONE;
  end

  assign expired = (cnt == lim - ONE);

  // R2: a running count never passes its limit
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < lim));
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_sync_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  logic   level,
  input  logic   fall,
  input  logic   expired,
  output phase_e st,
  output logic   cnt_clr,
  output logic   cnt_run
);
  phase_e nxt;

  always_comb begin
    nxt     = st;
    cnt_clr = 1'b0;
    if (!en) begin
      nxt     = PH_IDLE;
      cnt_clr = 1'b1;
    end else begin
      unique case (st)
        PH_IDLE: begin
          nxt     = PH_HWAIT;
          cnt_clr = 1'b1;
        end
        PH_HWAIT: begin
          if (level) begin
            nxt     = PH_HIGH;
            cnt_clr = 1'b1;
          end
        end
        PH_HIGH: begin
          if (fall) begin
            nxt     = PH_LOW;
            cnt_clr = 1'b1;
          end else if (expired) begin
            nxt     = PH_PULL;
            cnt_clr = 1'b1;
          end
        end
        PH_PULL: begin
          if (fall) begin
            nxt     = PH_LOW;
            cnt_clr = 1'b1;
          end
        end
        PH_LOW: begin
          if (fall)         cnt_clr = 1'b1;
          else if (expired) nxt     = PH_HWAIT;
        end
        default: begin
          nxt     = PH_IDLE;
          cnt_clr = 1'b1;
        end
      endcase
    end
  end

  assign cnt_run = (st == PH_LOW) || (st == PH_HIGH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= PH_IDLE;
    else        st <= nxt;
  end

  // R5/R6: a low line keeps the block waiting, with no timeout
  a_r5_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == PH_HWAIT && !level) |=> (st == PH_HWAIT));
  // R7: a bus fall during the high count starts the low phase
  a_r7_fall_aborts_high: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == PH_HIGH && fall) |=> (st == PH_LOW));
  // R2: an expired low count always lets go of the line
  a_r2_low_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == PH_LOW && expired && !fall) |=> (st == PH_HWAIT));
endmodule

// File: rtl/scl_clock_sync.sv
module scl_clock_sync
  import scl_sync_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] low_cnt,
  input  logic [CNT_W-1:0] high_cnt,
  input  logic             scl_i,
  output logic             scl_oe,
  output logic             scl_level,
  output logic             hold_wait,
  output logic             clk_active,
  output logic             fall_stb,
  output logic             rise_stb
);
  localparam logic [CNT_W-1:0] MIN_LIM = {{(CNT_W-1){1'b0}}, 1'b1};

  phase_e           st;
  logic             cnt_clr, cnt_run, expired;
  logic [CNT_W-1:0] low_lim, high_lim, cur_lim;

  scl_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_i),
    .level(scl_level), .fall_stb(fall_stb), .rise_stb(rise_stb)
  );

  // limits are captured once, as the block leaves idle; 0 is raised to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_lim  <= MIN_LIM;
      high_lim <= MIN_LIM;
    end else if (en && st == PH_IDLE) begin
      low_lim  <= (low_cnt  == '0) ? MIN_LIM : low_cnt;
      high_lim <= (high_cnt == '0) ? MIN_LIM : high_cnt;
    end
  end

  assign cur_lim = (st == PH_LOW) ? low_lim : high_lim;

  scl_period_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .run(cnt_run),
    .lim(cur_lim), .expired(expired)
  );

  scl_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en(en), .level(scl_level),
    .fall(fall_stb), .expired(expired), .st(st),
    .cnt_clr(cnt_clr), .cnt_run(cnt_run)
  );

  assign scl_oe     = (st == PH_PULL) || (st == PH_LOW);
  assign hold_wait  = (st == PH_HWAIT);
  assign clk_active = (st != PH_IDLE);

  // R10: dropping enable releases the line next cycle
  a_r10_disable_release: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_oe && !clk_active));
  // R9: limits do not move while the block runs
  a_r9_limits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_active && $past(clk_active)) |-> ($stable(low_lim) && $stable(high_lim)));
endmodule

// File: tb/scl_clock_sync_tb_top.sv
module scl_clock_sync_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] low_cnt = 8'd4, high_cnt = 8'd4;
  logic       ext_low = 1'b0;
  logic       scl_oe, scl_level, hold_wait, clk_active, fall_stb, rise_stb;
  logic       scl_bus;
  int         n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;   // 50 MHz
  assign scl_bus = ~(scl_oe | ext_low);

  scl_clock_sync dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .low_cnt(low_cnt), .high_cnt(high_cnt),
    .scl_i(scl_bus), .scl_oe(scl_oe), .scl_level(scl_level), .hold_wait(hold_wait),
    .clk_active(clk_active), .fall_stb(fall_stb), .rise_stb(rise_stb)
  );

  // {low, high} count pairs; expected lengths are max(x,1)+3
  localparam logic [15:0] VEC [6] = '{
    {8'd4, 8'd6}, {8'd1, 8'd1}, {8'd0, 8'd3},
    {8'd10, 8'd2}, {8'd7, 8'd0}, {8'd20, 8'd15}
  };

  function automatic int eff(input logic [7:0] v);
    return (v == 8'd0) ? 1 : int'(v);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_oe(input logic v);
    while (scl_oe !== v) @(negedge clk);
  endtask

  task automatic count_while(input logic v, output int n);
    n = 0;
    while (scl_oe === v) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic restart(input logic [7:0] l, input logic [7:0] h);
    en = 1'b0;
    ext_low = 1'b0;
    repeat (6) @(negedge clk);
    low_cnt  = l;
    high_cnt = h;
    en = 1'b1;
    wait_oe(1'b1);
    wait_oe(1'b0);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int h, l, n, rc, fc, bad;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(scl_oe == 1'b0, "R1 scl_oe in reset", scl_oe, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(scl_oe == 1'b0 && clk_active == 1'b0, "R1 idle after reset", {scl_oe, clk_active}, 0);
    check(hold_wait == 1'b0, "R1 hold_wait idle", hold_wait, 0);
    check(scl_level == 1'b1, "R1 scl_level idle", scl_level, 1);

    // R2/R3/R4: table walk, block alone on the bus
    for (int i = 0; i < 6; i++) begin
      logic [7:0] lv, hv;
      lv = VEC[i][15:8];
      hv = VEC[i][7:0];
      restart(lv, hv);
      count_while(1'b0, h);
      count_while(1'b1, l);
      check(h == eff(hv) + 3, (hv == 0) ? "R4 R3 high length" : "R3 high length", h, eff(hv) + 3);
      check(l == eff(lv) + 3, (lv == 0) ? "R4 R2 low length" : "R2 low length", l, eff(lv) + 3);
    end

    // R9: counts changed while enabled have no effect
    restart(8'd5, 8'd5);
    low_cnt  = 8'd20;
    high_cnt = 8'd20;
    count_while(1'b0, h);
    count_while(1'b1, l);
    check(h == 8, "R9 high ignores new count", h, 8);
    check(l == 8, "R9 low ignores new count", l, 8);

    // R8: one rise and one fall strobe per period (L=4,H=6 -> 16 cycles)
    restart(8'd4, 8'd6);
    rc = 0; fc = 0;
    for (int k = 0; k < 16; k++) begin
      rc += int'(rise_stb);
      fc += int'(fall_stb);
      @(negedge clk);
    end
    check(rc == 1, "R8 rise strobes per period", rc, 1);
    check(fc == 1, "R8 fall strobes per period", fc, 1);

    // R7: another master pulls low during our high count
    restart(8'd6, 8'd20);
    repeat (8) @(negedge clk);
    ext_low = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(scl_oe == 1'b0, "R7 no pull before third cycle", scl_oe, 0);
    @(negedge clk);
    check(scl_oe == 1'b1, "R7 pull on third cycle", scl_oe, 1);
    ext_low = 1'b0;
    count_while(1'b1, l);
    check(l == 6, "R7 low held from observed fall", l, 6);

    // R5/R6: slave stretches the low phase
    restart(8'd3, 8'd4);
    wait_oe(1'b1);
    ext_low = 1'b1;
    wait_oe(1'b0);
    check(hold_wait == 1'b1, "R5 wait flag after release", hold_wait, 1);
    bad = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (scl_oe !== 1'b0 || hold_wait !== 1'b1) bad++;
    end
    check(bad == 0, "R6 wait held without timeout", bad, 0);
    ext_low = 1'b0;
    n = 0;
    rc = 0;
    while (scl_oe !== 1'b1) begin
      @(negedge clk);
      rc += int'(rise_stb);
      n++;
    end
    check(n == 7, "R6 pull H+3 after line release", n, 7);
    check(hold_wait == 1'b0, "R6 wait flag cleared", hold_wait, 0);
    check(rc == 1, "R8 single rise after stretch", rc, 1);

    // R10: disable while pulling low
    wait_oe(1'b1);
    en = 1'b0;
    @(negedge clk);
    check(scl_oe == 1'b0, "R10 release on disable", scl_oe, 0);
    check(clk_active == 1'b0, "R10 idle on disable", clk_active, 0);

    finish_run();
  end
endmodule